// File: doc/BRIEF.md
# Datapath Self-Test Sequencer with PN Injection and CRC Signature

This block tests the digital datapath of a two-channel data converter without any analog input. A register write starts a run. For a fixed number of cycles, pseudorandom words take the place of the converter samples at the datapath input. A CRC unit at the datapath output folds every word that comes out into a 16-bit signature. When the run ends, the signature is compared against an expected value fixed at build time. A status bit records the result, and the enable bit clears itself.

Between runs the datapath forwards the converter samples. The pseudorandom generator keeps its state between runs. A run that does not ask for a reseed therefore continues the earlier sequence, and its signature fails unless that state happens to equal the seed. The output stream carries a valid flag but accepts no back-pressure. The converter produces a sample on every clock, so the consumer must take a word on every cycle in which `dout_valid` is high.

Top module: `pn_selftest`

## Requirements
- R1: A write to address 0x0E with bit 0 set, while idle, starts a run. `busy` rises after that clock edge and stays high for 513 cycles. A write to 0x0E with bit 0 clear starts nothing.
- R2: During a run, exactly 512 test words leave the datapath, one per cycle with `dout_valid` high. The first word appears one cycle after the start edge.
- R3: The test source is a 23-bit LFSR that shifts toward the MSB, with new bit = s[22] xor s[17]. Channel A carries s[9:0] and channel B carries its bitwise inverse. The LFSR advances once per word.
- R4: If bit 2 of the start write is 1, the LFSR is loaded with all ones before the first word. If bit 2 is 0, the LFSR continues from the state it held.
- R5: The signature is a CRC-16 (polynomial 0x1021, seed 0xFFFF) over the 20 bits {A,B} of each word, MSB first. At the end of the run, status bit 0 at address 0x24 is 1 if and only if the signature equals `EXPECT_SIG`. A start clears this bit.
- R6: Reading 0x0E returns the enable in bit 0 and the stored init bit in bit 2. The enable reads 1 while a run is in progress and returns to 0 by itself at the end.
- R7: A start written while busy is ignored. It leaves the length of the run, the stored init bit and the stream unchanged.
- R8: Synchronous active-high reset clears busy, the enable, the pass bit and the output valid flag, and loads the LFSR with all ones.
- R9: Outside a run, `dout_a`, `dout_b` and `dout_valid` follow `adc_a`, `adc_b` and `adc_valid` with a latency of one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| cfg_raddr | input | 8 | Register read address |
| cfg_rdata | output | 8 | Register read data (combinational) |
| adc_a | input | 10 | Converter sample, channel A |
| adc_b | input | 10 | Converter sample, channel B |
| adc_valid | input | 1 | Converter sample valid |
| dout_a | output | 10 | Datapath output, channel A |
| dout_b | output | 10 | Datapath output, channel B |
| dout_valid | output | 1 | Datapath output valid |
| busy | output | 1 | Self-test run in progress |

## Verification
The assertions check on every cycle:
- the run length, using a counter of their own;
- that each test word carries an inverted copy on channel B;
- that the enable readback equals `busy`;
- that the pass bit changes only at the edges of a run;
- the reset state.

Only the bench scenarios can show that the words follow the LFSR sequence, that a reseed or a resumed sequence gives the pass or fail result predicted by an independent signature model, that a start issued mid-run is ignored, and that samples pass through between runs.

// File: rtl/pn_st_pkg.sv
package pn_st_pkg;
  localparam int unsigned WORD_W   = 10;
  localparam int unsigned NCH      = 2;
  localparam int unsigned LFSR_W   = 23;
  localparam int unsigned LFSR_TAP = 18;
  localparam int unsigned SIG_W    = 16;
  localparam logic [15:0] SIG_POLY = 16'h1021;
  localparam logic [15:0] SIG_SEED = 16'hFFFF;
  localparam int unsigned RUN_LEN  = 512;
  localparam logic [7:0]  CTRL_ADDR = 8'h0E;
  localparam logic [7:0]  STAT_ADDR = 8'h24;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned INIT_BIT = 2;

  // Fold a word into the signature, MSB first.
  function automatic logic [SIG_W-1:0] sig_fold(input logic [SIG_W-1:0] c,
                                                input logic [NCH*WORD_W-1:0] d);
    logic [SIG_W-1:0] r;
    logic fb;
    r = c;
    for (int i = NCH*WORD_W-1; i >= 0; i--) begin
      fb = r[SIG_W-1] ^ d[i];
      r  = {r[SIG_W-2:0], 1'b0};
      if (fb) r = r ^ SIG_POLY[SIG_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int unsigned W   = 23,
  parameter int unsigned TAP = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_ld,
  input  logic         adv,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst || seed_ld) state <= '1;
    else if (adv)       state <= {state[W-2:0], state[W-1] ^ state[TAP-1]};
  end
endmodule

// File: rtl/sig_crc.sv
module sig_crc
  import pn_st_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic [NCH*WORD_W-1:0]   din,
  output logic [SIG_W-1:0]        sig,
  output logic [SIG_W-1:0]        sig_next
);
  always_comb sig_next = sig_fold(sig, din);

  always_ff @(posedge clk) begin
    if (rst || clr) sig <= SIG_SEED[SIG_W-1:0];
    else if (en)    sig <= sig_next;
  end
endmodule

// File: rtl/chan_dp.sv
module chan_dp #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_tst,
  input  logic [W-1:0] tst_word,
  input  logic [W-1:0] adc_word,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= sel_tst ? tst_word : adc_word;
  end
endmodule

// File: rtl/pn_selftest.sv
module pn_selftest
  import pn_st_pkg::*;
#(
  parameter logic [15:0] EXPECT_SIG = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_waddr,
  input  logic [7:0]  cfg_wdata,
  input  logic [7:0]  cfg_raddr,
  output logic [7:0]  cfg_rdata,
  input  logic [9:0]  adc_a,
  input  logic [9:0]  adc_b,
  input  logic        adc_valid,
  output logic [9:0]  dout_a,
  output logic [9:0]  dout_b,
  output logic        dout_valid,
  output logic        busy
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN) + 1;

  logic              busy_q, init_q, pass_q, tst_q, valid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ctrl_wr, start, inj, finish;
  logic [LFSR_W-1:0] pn_state;
  logic [SIG_W-1:0]  sig, sig_next;
  logic [WORD_W-1:0] tst_w  [NCH];
  logic [WORD_W-1:0] adc_w  [NCH];
  logic [WORD_W-1:0] dout_w [NCH];

  always_comb begin
    ctrl_wr = cfg_we && (cfg_waddr == CTRL_ADDR) && !busy_q;
    start   = ctrl_wr && cfg_wdata[EN_BIT];
    inj     = busy_q && (cnt_q != CNT_W'(RUN_LEN));
    finish  = busy_q && tst_q && !inj;
  end

  pn_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk(clk), .rst(rst),
    .seed_ld(start && cfg_wdata[INIT_BIT]),
    .adv(inj),
    .state(pn_state)
  );

  assign adc_w[0] = adc_a;
  assign adc_w[1] = adc_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    if (ch == 0) begin : g_true
      assign tst_w[ch] = pn_state[WORD_W-1:0];
    end else begin : g_inv
      assign tst_w[ch] = ~pn_state[WORD_W-1:0];
    end
    chan_dp #(.W(WORD_W)) u_dp (
      .clk(clk), .rst(rst), .sel_tst(inj),
      .tst_word(tst_w[ch]), .adc_word(adc_w[ch]), .dout(dout_w[ch])
    );
  end

  sig_crc u_sig (
    .clk(clk), .rst(rst), .clr(start), .en(tst_q),
    .din({dout_w[0], dout_w[1]}),
    .sig(sig), .sig_next(sig_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      init_q  <= 1'b0;
      pass_q  <= 1'b0;
      tst_q   <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      tst_q   <= inj;
      valid_q <= inj | adc_valid;
      if (ctrl_wr) init_q <= cfg_wdata[INIT_BIT];
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        pass_q <= 1'b0;
      end else begin
        if (inj) cnt_q <= cnt_q + 1'b1;
        if (finish) begin
          busy_q <= 1'b0;
          pass_q <= (sig_next == EXPECT_SIG[SIG_W-1:0]);
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_raddr == CTRL_ADDR) begin
      cfg_rdata[EN_BIT]   = busy_q;
      cfg_rdata[INIT_BIT] = init_q;
    end else if (cfg_raddr == STAT_ADDR) begin
      cfg_rdata[0] = pass_q;
    end
  end

  assign dout_a     = dout_w[0];
  assign dout_b     = dout_w[1];
  assign dout_valid = valid_q;
  assign busy       = busy_q;
endmodule

// File: rtl/pn_selftest_chk.sv
module pn_selftest_chk #(
  parameter int unsigned RUN_LEN   = 512,
  parameter logic [7:0]  CTRL_ADDR = 8'h0E
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       dout_valid,
  input logic [9:0] dout_a,
  input logic [9:0] dout_b,
  input logic       pass,
  input logic [7:0] cfg_raddr,
  input logic [7:0] cfg_rdata
);
  localparam int unsigned CW = $clog2(RUN_LEN) + 2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  p_run_end_r1: assert property (@(posedge clk) disable iff (rst)
    busy && run_cnt == CW'(RUN_LEN) |=> !busy);
  p_no_early_end_r1: assert property (@(posedge clk) disable iff (rst)
    busy && run_cnt < CW'(RUN_LEN) |=> busy);
  p_word_pair_r3: assert property (@(posedge clk) disable iff (rst)
    busy && run_cnt != '0 |-> dout_valid && (dout_b == ~dout_a));
  p_en_readback_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_raddr == CTRL_ADDR |-> cfg_rdata[0] == busy);
  p_pass_edges_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(pass) |-> ($rose(busy) || $fell(busy)));
  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> !busy && !pass && !dout_valid);
endmodule

bind pn_selftest pn_selftest_chk #(.RUN_LEN(pn_st_pkg::RUN_LEN), .CTRL_ADDR(pn_st_pkg::CTRL_ADDR)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .dout_valid(dout_valid),
  .dout_a(dout_a), .dout_b(dout_b), .pass(pass_q),
  .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_pn_selftest.sv
module sim_pn_selftest;
  function automatic logic [22:0] lfsr_step(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [15:0] ref_sig(input logic [22:0] s0);
    logic [22:0] s;
    logic [15:0] c;
    logic [19:0] d;
    logic fb;
    s = s0;
    c = 16'hFFFF;
    for (int k = 0; k < 512; k++) begin
      d = {s[9:0], ~s[9:0]};
      for (int i = 19; i >= 0; i--) begin
        fb = c[15] ^ d[i];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
      s = lfsr_step(s);
    end
    return c;
  endfunction

  localparam logic [15:0] EXP = ref_sig(23'h7FFFFF);

  // {init bit, expected pass, start written mid-run}
  localparam logic [2:0] ROWS [5] = '{3'b010, 3'b000, 3'b111, 3'b000, 3'b110};

  logic       clk = 0, rst = 1;
  logic       cfg_we = 0;
  logic [7:0] cfg_waddr = 0, cfg_wdata = 0, cfg_raddr = 0;
  logic [7:0] cfg_rdata;
  logic [9:0] adc_a = 0, adc_b = 0;
  logic       adc_valid = 0;
  logic [9:0] dout_a, dout_b;
  logic       dout_valid, busy;

  int checks = 0, errors = 0;
  logic [22:0] m_state = 23'h7FFFFF;

  always #10 clk = ~clk;

  pn_selftest #(.EXPECT_SIG(EXP)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .adc_a(adc_a), .adc_b(adc_b), .adc_valid(adc_valid),
    .dout_a(dout_a), .dout_b(dout_b), .dout_valid(dout_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cfg_raddr = a;
    #1 d = cfg_rdata;
  endtask

  // Starts a run and follows it to the end; the result is checked against exp_pass.
  task automatic run(input bit init, input bit exp_pass, input bit mid);
    int nb, words;
    bit word_ok;
    logic [7:0] d;
    if (init) m_state = 23'h7FFFFF;
    wr(8'h0E, init ? 8'h05 : 8'h01);
    nb = 1; words = 0; word_ok = 1;
    rd(8'h0E, d);
    chk(d[0] == 1'b1, "R6 enable set", d, 1);
    for (int k = 1; k < 600 && busy; k++) begin
      if (mid && k == 100) begin
        cfg_we = 1; cfg_waddr = 8'h0E; cfg_wdata = 8'h01;
      end else if (mid && k == 101) begin
        cfg_we = 0;
      end
      @(negedge clk);
      if (busy) begin
        nb++;
        words++;
        if (!(dout_valid && dout_a == m_state[9:0] && dout_b == ~m_state[9:0])) begin
          if (word_ok) chk(0, "R3 word", {dout_a, dout_b}, {m_state[9:0], ~m_state[9:0]});
          word_ok = 0;
        end
        m_state = lfsr_step(m_state);
      end
    end
    chk(word_ok, "R2 R3 R4 stream", word_ok, 1);
    chk(nb == 513, "R1 busy length", nb, 513);
    chk(words == 512, "R2 word count", words, 512);
    chk(dout_valid == 1'b0, "R2 valid drops", dout_valid, 0);
    rd(8'h24, d);
    chk(d[0] == exp_pass, "R5 pass flag", d[0], exp_pass);
    rd(8'h0E, d);
    chk(d == (init ? 8'h04 : 8'h00), "R6 R7 ctrl readback", d, init ? 8'h04 : 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && dout_valid == 0, "R8 reset outputs", {busy, dout_valid}, 0);
    rd(8'h0E, d); chk(d == 0, "R8 reset ctrl", d, 0);
    rd(8'h24, d); chk(d == 0, "R8 reset status", d, 0);

    for (int r = 0; r < 5; r++) begin
      run(ROWS[r][2], ROWS[r][1], ROWS[r][0]);
      if (r == 2) begin
        // A control write without the enable starts nothing.
        wr(8'h0E, 8'h04);
        repeat (3) begin
          chk(busy == 0, "R1 no start without enable", busy, 0);
          @(negedge clk);
        end
        rd(8'h0E, d); chk(d == 8'h04, "R6 init stored", d, 8'h04);
      end
    end

    // Pass-through of converter samples between runs.
    adc_a = 10'h155; adc_b = 10'h2AA; adc_valid = 1;
    @(negedge clk);
    chk(dout_a == 10'h155 && dout_b == 10'h2AA && dout_valid, "R9 passthrough", {dout_a, dout_b}, {10'h155, 10'h2AA});
    adc_a = 10'h0F3; adc_valid = 0;
    @(negedge clk);
    chk(dout_a == 10'h0F3 && !dout_valid, "R9 valid follows", {dout_valid, dout_a}, {1'b0, 10'h0F3});

    // Reset in the middle of a run, then a resumed run starts from the reset seed.
    wr(8'h0E, 8'h01);
    repeat (50) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(busy == 0 && dout_valid == 0, "R8 reset mid-run", {busy, dout_valid}, 0);
    rd(8'h24, d); chk(d == 0, "R8 status cleared", d, 0);
    m_state = 23'h7FFFFF;
    run(1'b0, 1'b1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule